// File: doc/BRIEF.md
# Pulse Accumulator with Event and Gated-Time Modes

This block keeps a 16-bit running count that software can read and load through a small byte-addressed register port. In event mode it adds one for every chosen edge (rising or falling) seen on an external pin. In gated mode it adds one on every strobe of a clock-enable tick while the pin, used as a gate, sits at its active level. It is meant to sit beside a prescaler that supplies the tick and an interrupt controller that takes its two request levels.

Two sticky flags record what happened. One marks a roll-over of the count from its top value to zero. The other marks an input event: the selected edge in event mode, or the end of a gate window in gated mode. Software clears a flag by writing a one to its bit. When fast clearing is turned on, any touch of the count register clears both flags. The count can be read or loaded as a 16-bit word in a single cycle, or one byte at a time.

Top module: `pulse_accum`

## Requirements
- R1: After a synchronous active-low reset the count reads 0x0000, the flag register reads 0 and both interrupt outputs are low.
- R2: In event mode (`mode_gated`=0) the count rises by exactly one for each edge of `acc_pin` of the kind picked by `edge_rise` (1 = rising, 0 = falling), after a two-flop synchronizer; edges of the other kind leave it unchanged.
- R3: In event mode each counted edge sets the event flag (flag register bit 0).
- R4: In gated mode (`mode_gated`=1) the count rises by one on each cycle with `tick` high while the synchronized pin equals `gate_high`; ticks outside that level are not counted.
- R5: In gated mode the end of the gate window (active to inactive level) sets the event flag; the start of the window does not.
- R6: A step of the count from 0xFFFF to 0x0000 sets the overflow flag (flag register bit 1).
- R7: Reading address 0 returns the overflow flag in bit 1, the event flag in bit 0, and zero in bits 15 to 2.
- R8: Writing address 0 clears the overflow flag when data bit 1 is one and the event flag when data bit 0 is one; a zero bit leaves its flag as it was.
- R9: With `fast_clr`=1 any read or write at address 1 or 2 clears both flags; with `fast_clr`=0 such access leaves the flags alone.
- R10: A word access (`bus_word`=1) at address 1 reads or loads all 16 bits in one cycle; a byte access at address 1 touches bits 15:8 and at address 2 bits 7:0, through `bus_wdata[7:0]`/`bus_rdata[7:0]`, keeping the other byte.
- R11: A bus load of the count wins over an increment in the same cycle, and a flag set wins over a flag clear in the same cycle.
- R12: With `acc_en`=0 neither the count changes (except by bus load) nor any flag is set.
- R13: `ovf_irq` is high exactly while the overflow flag and `ovf_ie` are both one; `evt_irq` likewise with the event flag and `evt_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Enables counting and flag setting |
| mode_gated | input | 1 | 0 = event mode, 1 = gated time mode |
| edge_rise | input | 1 | Event mode edge: 1 rising, 0 falling |
| gate_high | input | 1 | Gated mode active level of the pin |
| tick | input | 1 | Clock-enable strobe for gated mode |
| fast_clr | input | 1 | Count access clears both flags |
| acc_pin | input | 1 | Asynchronous event / gate pin |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 16-bit access (address 1 only) |
| bus_addr | input | 2 | 0 flags, 1 count high / word, 2 count low |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when idle |
| ovf_ie | input | 1 | Overflow interrupt enable |
| evt_ie | input | 1 | Event interrupt enable |
| ovf_irq | output | 1 | Overflow interrupt request level |
| evt_irq | output | 1 | Event interrupt request level |

## Verification
Event mode is driven with random pin waveforms under both edge selections, so a design that counts the wrong edge, both edges or misses edges gives a different total. Gated mode gets random tick trains inside and outside the gate window with both polarities, separating level-qualified counting from free counting and trailing-edge flagging from leading-edge flagging. Directed cases load 0xFFFF to force the wrap, collide a load with an increment and a flag set with a clear, and mix byte and word access with fast clearing on and off.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and register address codes of the pulse
// accumulator. Assumes a 2-bit register address space.
package pacc_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NLANES = CNT_W / BYTE_W;

    typedef enum logic [1:0] {
        RA_FLAGS  = 2'd0,
        RA_CNT_HI = 2'd1,
        RA_CNT_LO = 2'd2
    } pacc_addr_e;

    // Flag bit positions inside the flag register.
    localparam int FB_EVT = 0;
    localparam int FB_OVF = 1;
endpackage

// File: rtl/pacc_sync_edge.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous pin through SYNC flops and reports the
// synchronized level plus one-cycle rise and fall pulses.
// Assumes SYNC >= 2 and that pin pulses last longer than a clock period.
module pacc_sync_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [SYNC-1:0] chain_q;
    logic            prev_q;

    // Shift the pin through the synchronizer chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC-2:0], pin};
            prev_q  <= chain_q[SYNC-1];
        end
    end

    // Derive level and edge pulses from the last two synchronized samples.
    always_comb begin
        lvl  = chain_q[SYNC-1];
        rise = chain_q[SYNC-1] & ~prev_q;
        fall = ~chain_q[SYNC-1] & prev_q;
    end
endmodule

// File: rtl/pacc_counter.sv
`timescale 1ns/1ps
// Up-counter with per-byte load lanes. A load on any lane wins over the
// increment in that cycle. Reports a wrap pulse when it steps from all
// ones to zero. Assumes W is a multiple of LANE_W.
module pacc_counter #(
    parameter int W      = 16,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    input  logic [W/LANE_W-1:0] ld_mask,
    input  logic [W-1:0]        ld_val,
    output logic [W-1:0]        cnt,
    output logic                wrap
);
    localparam int LANES = W / LANE_W;
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         any_ld;

    // Detect whether any byte lane is being loaded this cycle.
    always_comb begin
        any_ld = |ld_mask;
        wrap   = inc && !any_ld && (cnt_q == TOP);
    end

    // One register slice per byte lane: load, increment or hold.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W-1:0] nxt_full;
        always_comb nxt_full = cnt_q + {{(W-1){1'b0}}, 1'b1};
        // Update this lane from the bus, from the increment or keep it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[g*LANE_W +: LANE_W] <= '0;
            else if (ld_mask[g])
                cnt_q[g*LANE_W +: LANE_W] <= ld_val[g*LANE_W +: LANE_W];
            else if (inc && !any_ld)
                cnt_q[g*LANE_W +: LANE_W] <= nxt_full[g*LANE_W +: LANE_W];
        end
    end

    assign cnt = cnt_q;

    // R11: a load decides the next count whatever the increment does.
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (&ld_mask) |=> (cnt_q == $past(ld_val)));

    // R2/R4: without a load the count moves by at most one per cycle.
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ld) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pacc_flags.sv
`timescale 1ns/1ps
// Sticky flag bank. Each bit is set by its set strobe and cleared by its
// clear strobe; a set in the same cycle as a clear leaves the bit set.
module pacc_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_q;

    // Apply clears first, then sets, so a set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr) | set;
    end

    assign flags = flags_q;

    // R11: a set strobe always leaves its flag high next cycle.
    for (genvar g = 0; g < N; g++) begin : g_chk
        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flags_q[g]);
    end
endmodule

// File: rtl/pulse_accum.sv
`timescale 1ns/1ps
// Pulse accumulator top: event or gated-time counting of an external pin,
// overflow and event flags with write-one-to-clear and optional fast clear,
// byte and word register access, and flag-and-enable interrupt levels.
// Assumes tick is a one-cycle clock-enable from an external prescaler.
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             mode_gated,
    input  logic             edge_rise,
    input  logic             gate_high,
    input  logic             tick,
    input  logic             fast_clr,
    input  logic             acc_pin,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic             bus_word,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ovf_ie,
    input  logic             evt_ie,
    output logic             ovf_irq,
    output logic             evt_irq
);
    logic              pin_lvl, pin_rise, pin_fall;
    logic              ev_pulse, gate_act, gate_end;
    logic              inc, wrap;
    logic              hit_flags, hit_hi, hit_lo, cnt_acc;
    logic [NLANES-1:0] ld_mask;
    logic [CNT_W-1:0]  ld_val, cnt;
    logic [1:0]        fl_set, fl_clr, flags;

    pacc_sync_edge #(.SYNC(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(acc_pin),
        .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    // Pick the counting source and the event-flag source for the mode.
    always_comb begin
        ev_pulse = edge_rise ? pin_rise : pin_fall;
        gate_act = (pin_lvl == gate_high);
        gate_end = gate_high ? pin_fall : pin_rise;
        inc      = acc_en && (mode_gated ? (tick && gate_act) : ev_pulse);
    end

    // Decode the register access and build the count load lanes.
    always_comb begin
        hit_flags = bus_sel && (bus_addr == RA_FLAGS);
        hit_hi    = bus_sel && (bus_addr == RA_CNT_HI);
        hit_lo    = bus_sel && (bus_addr == RA_CNT_LO);
        cnt_acc   = hit_hi || hit_lo;
        ld_mask   = '0;
        ld_val    = bus_wdata;
        if (bus_we && hit_hi && bus_word) begin
            ld_mask = 2'b11;
        end else if (bus_we && hit_hi) begin
            ld_mask = 2'b10;
            ld_val  = {bus_wdata[BYTE_W-1:0], bus_wdata[BYTE_W-1:0]};
        end else if (bus_we && hit_lo) begin
            ld_mask = 2'b01;
        end
    end

    pacc_counter #(.W(CNT_W), .LANE_W(BYTE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .ld_mask(ld_mask),
        .ld_val(ld_val), .cnt(cnt), .wrap(wrap)
    );

    // Form flag set and clear strobes from events and bus accesses.
    always_comb begin
        fl_set         = '0;
        fl_set[FB_OVF] = wrap;
        fl_set[FB_EVT] = acc_en && (mode_gated ? gate_end : ev_pulse);
        if (fast_clr && cnt_acc)
            fl_clr = 2'b11;
        else if (bus_we && hit_flags)
            fl_clr = bus_wdata[1:0];
        else
            fl_clr = 2'b00;
    end

    pacc_flags #(.N(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(fl_set), .clr(fl_clr), .flags(flags)
    );

    // Return the addressed register; idle or unmapped reads give zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_flags)
            bus_rdata = {{(CNT_W-2){1'b0}}, flags};
        else if (hit_hi && bus_word)
            bus_rdata = cnt;
        else if (hit_hi)
            bus_rdata = {{(CNT_W-BYTE_W){1'b0}}, cnt[CNT_W-1:BYTE_W]};
        else if (hit_lo)
            bus_rdata = {{(CNT_W-BYTE_W){1'b0}}, cnt[BYTE_W-1:0]};
    end

    // Drive the interrupt request levels.
    always_comb begin
        ovf_irq = flags[FB_OVF] & ovf_ie;
        evt_irq = flags[FB_EVT] & evt_ie;
    end

    // R6: a counter wrap shows up as a set overflow flag.
    p_wrap_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flags[FB_OVF]);

    // R12: while disabled and not loaded, the count holds.
    p_hold_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && ld_mask == '0) |=> (cnt == $past(cnt)));

    // R12: while disabled, a clear flag stays clear.
    p_no_evt_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !flags[FB_EVT]) |=> !flags[FB_EVT]);

    // R9: fast clear with no new event leaves both flags clear.
    p_fast_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_clr && cnt_acc && fl_set == 2'b00) |=> (flags == 2'b00));

    // R7: the upper flag register bits never read as one.
    p_flag_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_flags |-> (bus_rdata[CNT_W-1:2] == '0));
endmodule

// File: tb/pulse_accum_bench.sv
`timescale 1ns/1ps
module pulse_accum_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_en, mode_gated, edge_rise, gate_high, tick, fast_clr, acc_pin;
    logic        bus_sel, bus_we, bus_word;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        ovf_ie, evt_ie, ovf_irq, evt_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_accum u_pulse_accum (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .mode_gated(mode_gated),
        .edge_rise(edge_rise), .gate_high(gate_high), .tick(tick),
        .fast_clr(fast_clr), .acc_pin(acc_pin), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_ie(ovf_ie),
        .evt_ie(evt_ie), .ovf_irq(ovf_irq), .evt_irq(evt_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected count after a byte load of the high half.
    function automatic logic [15:0] f_load_hi(input logic [15:0] old, input logic [7:0] b);
        return {b, old[7:0]};
    endfunction
    // Expected count after a byte load of the low half.
    function automatic logic [15:0] f_load_lo(input logic [15:0] old, input logic [7:0] b);
        return {old[15:8], b};
    endfunction
    // Does a pin change from a to b count as the chosen edge?
    function automatic bit f_edge_hit(input bit a, input bit b, input bit rise_sel);
        return rise_sel ? (!a && b) : (a && !b);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input bit w, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_word = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_word = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, input bit w, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_word = w; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_word = 0;
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, exp_cnt;
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        rst_n = 0; acc_en = 0; mode_gated = 0; edge_rise = 1; gate_high = 1;
        tick = 0; fast_clr = 0; acc_pin = 0; bus_sel = 0; bus_we = 0;
        bus_word = 0; bus_addr = 0; bus_wdata = 0; ovf_ie = 1; evt_ie = 1;
        cyc(4);
        rst_n = 1;
        cyc(1);

        // R1: reset state.
        bus_read(2'd1, 1, rd); check("R1 count", rd, 16'h0000);
        bus_read(2'd0, 0, rd); check("R1 flags", rd, 16'h0000);
        check("R1 irq", {14'd0, ovf_irq, evt_irq}, 16'h0000);

        // R2/R3: event mode, both edge selections, random pin waveform.
        acc_en = 1;
        for (int sel = 1; sel >= 0; sel--) begin
            edge_rise = sel[0];
            bus_write(2'd1, 1, 16'h0000);
            bus_write(2'd0, 0, 16'h0003);
            exp_cnt = 0;
            for (int i = 0; i < 40; i++) begin
                bit nv;
                nv = 1'($urandom % 2);
                if (f_edge_hit(acc_pin, nv, sel[0])) exp_cnt++;
                @(negedge clk) acc_pin = nv;
                cyc(4 + ($urandom % 4));
            end
            bus_read(2'd1, 1, rd); check("R2 event count", rd, exp_cnt);
            bus_read(2'd0, 0, rd);
            check("R3 event flag", rd, (exp_cnt != 0) ? 16'h0001 : 16'h0000);
        end

        // R13: event irq follows flag and enable.
        check("R13 evt_irq on", {15'd0, evt_irq}, 16'h0001);
        evt_ie = 0; #1;
        check("R13 evt_irq masked", {15'd0, evt_irq}, 16'h0000);
        evt_ie = 1;

        // R10: byte loads keep the other byte; word read is coherent.
        bus_write(2'd1, 1, 16'hA5C3);
        bus_write(2'd1, 0, 16'h0012);
        bus_read(2'd1, 1, rd); check("R10 high byte load", rd, f_load_hi(16'hA5C3, 8'h12));
        bus_write(2'd2, 0, 16'h0034);
        bus_read(2'd1, 1, rd); check("R10 low byte load", rd, f_load_lo(16'h12C3, 8'h34));
        bus_read(2'd1, 0, rd); check("R10 high byte read", rd, 16'h0012);
        bus_read(2'd2, 0, rd); check("R10 low byte read", rd, 16'h0034);

        // R6: load 0xFFFF, one rising edge wraps and sets overflow.
        edge_rise = 1;
        @(negedge clk) acc_pin = 0; cyc(4);
        bus_write(2'd0, 0, 16'h0003);
        bus_write(2'd1, 1, 16'hFFFF);
        @(negedge clk) acc_pin = 1; cyc(4);
        bus_read(2'd1, 1, rd); check("R6 wrap count", rd, 16'h0000);
        bus_read(2'd0, 0, rd); check("R6 R7 flags after wrap", rd, 16'h0003);
        check("R13 ovf_irq", {15'd0, ovf_irq}, 16'h0001);

        // R8: write-one-to-clear, zeros keep the flag.
        bus_write(2'd0, 0, 16'hFFFD);
        bus_read(2'd0, 0, rd); check("R8 clear event only", rd, 16'h0002);
        bus_write(2'd0, 0, 16'h0000);
        bus_read(2'd0, 0, rd); check("R8 zero write keeps", rd, 16'h0002);

        // R9: count access without fast clear keeps, with it clears.
        bus_read(2'd2, 0, rd);
        bus_read(2'd0, 0, rd); check("R9 no fast clear", rd, 16'h0002);
        fast_clr = 1;
        bus_read(2'd2, 0, rd);
        fast_clr = 0;
        bus_read(2'd0, 0, rd); check("R9 fast clear by read", rd, 16'h0000);
        @(negedge clk) acc_pin = 0; cyc(4);
        @(negedge clk) acc_pin = 1; cyc(4);
        fast_clr = 1;
        bus_write(2'd1, 0, 16'h0000);
        fast_clr = 0;
        bus_read(2'd0, 0, rd); check("R9 fast clear by write", rd, 16'h0000);

        // R4/R5: gated mode with both polarities and random ticks.
        mode_gated = 1;
        for (int pol = 1; pol >= 0; pol--) begin
            gate_high = pol[0];
            @(negedge clk) acc_pin = ~pol[0]; cyc(5);
            bus_write(2'd0, 0, 16'h0003);
            bus_write(2'd1, 1, 16'h0000);
            // Ticks outside the window must not count.
            for (int i = 0; i < 10; i++) begin @(negedge clk) tick = 1'($urandom % 2); end
            @(negedge clk) tick = 0;
            // Open the window (leading edge) and check no event flag.
            acc_pin = pol[0]; cyc(5);
            bus_read(2'd0, 0, rd); check("R5 leading edge no flag", rd, 16'h0000);
            exp_cnt = 0;
            for (int i = 0; i < 30; i++) begin
                bit t;
                t = 1'($urandom % 2);
                @(negedge clk) tick = t;
                if (t) exp_cnt++;
            end
            @(negedge clk) tick = 0;
            acc_pin = ~pol[0]; cyc(5);
            bus_read(2'd1, 1, rd); check("R4 gated count", rd, exp_cnt);
            bus_read(2'd0, 0, rd); check("R5 trailing edge flag", rd, 16'h0001);
        end

        // R11: load collides with increment; set collides with clear.
        gate_high = 1;
        @(negedge clk) acc_pin = 1; cyc(5);
        bus_write(2'd0, 0, 16'h0003);
        @(negedge clk);
        tick = 1; bus_sel = 1; bus_we = 1; bus_word = 1; bus_addr = 2'd1; bus_wdata = 16'hFFFF;
        @(negedge clk);
        tick = 1; bus_word = 0; bus_addr = 2'd0; bus_wdata = 16'h0002;
        @(negedge clk);
        tick = 0; bus_sel = 0; bus_we = 0;
        bus_read(2'd0, 0, rd); check("R11 set beats clear", rd, 16'h0002);
        bus_read(2'd1, 1, rd); check("R11 load beats increment", rd, 16'h0000);

        // R12: disabled block neither counts nor flags.
        bus_write(2'd0, 0, 16'h0003);
        acc_en = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk) tick = 1; end
        @(negedge clk) tick = 0; acc_pin = 0; cyc(5);
        bus_read(2'd1, 1, rd); check("R12 disabled count", rd, 16'h0000);
        bus_read(2'd0, 0, rd); check("R12 disabled flag", rd, 16'h0000);
        mode_gated = 0;
        @(negedge clk) acc_pin = 1; cyc(5);
        bus_read(2'd1, 1, rd); check("R12 disabled event", rd, 16'h0000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule